// File: doc/BRIEF.md
# Parallel Additive Link Scrambler

This block whitens a parallel data word for a serial link by XORing every data bit with one bit of a pseudo-random keystream. The keystream comes from a 16-bit Galois shift register that runs by itself and never takes in data. Because the data never reaches the shift register, the same block undoes its own work. A receiver that starts from the same seed and sees the same sequence of valid words gets the original data back.

The word is one or more 8-bit lanes. In a single clock, the shift register advances by as many steps as the word has bits. Keystream bits are spent from lane 0 upward, and inside each lane from bit 0 to bit 7. The result is registered, so it leaves the block one cycle after the valid word enters. Words without a valid strobe do not advance the shift register and do not disturb the output. The word width is a parameter, and the byte stream that comes out does not depend on it.

Top module: `pipe_scrambler`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, out_valid is 0 and out_data is all zeros. Reset loads the 16-bit shift register with 16'hFFFF.
- R2: Each keystream bit is the present state's bit 0. The next state is the state shifted right by one and, when that bit was 1, XORed with 16'h9C00. From the reset seed the first three keystream bytes are 8'hFF, 8'h17 and 8'hC0.
- R3: Keystream bit k of a word goes to data bit k. Lane j holds bits 8j to 8j+7, and keystream bits are spent on lane 0 first, bit 0 first within each lane.
- R4: out_data equals in_data XOR the keystream. The keystream does not depend on the data, so any two data streams see the same keystream.
- R5: In a cycle with in_valid low, out_data keeps its value and the shift register does not advance.
- R6: Latency is one cycle. out_valid is in_valid delayed by one clock.
- R7: An 8-bit instance fed the same byte stream produces the same output bytes as a 64-bit instance.
- R8: Two instances in series (scrambler then descrambler) return the original data, including across gaps in valid.
- R9: Reset wins over in_valid: a valid word that is present while rst_n is low leaves no trace. The first valid word after release uses the seed keystream.
- R10: A reset in the middle of a stream reseeds the shift register, so the next word is scrambled with the keystream that starts at the seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word strobe; advances the keystream |
| in_data | input | WORD_W | Input word, lane 0 in bits 7:0 |
| out_valid | output | 1 | Output word strobe, one cycle after in_valid |
| out_data | output | WORD_W | Scrambled (or descrambled) word |

## Verification
A wrong shift-register state appears in the very next valid output word. It corrupts that word's keystream, and it corrupts every word after it, because nothing ever resynchronises the register. A state that advances in an idle cycle shows up the same way, on the first valid word after the gap. A lane or bit-order error is caught in the first word after reset, which is compared against the known seed bytes. A width-dependent error is caught by comparing byte streams from the 8-bit and 64-bit instances.

// File: rtl/pscr_pkg.sv
package pscr_pkg;
  localparam int LFSR_W = 16;
  localparam int LANE_W = 8;
  typedef logic [LFSR_W-1:0] lfsr_t;
  // right-shifting Galois tap mask and reset seed
  localparam lfsr_t TAP_MASK = 16'h9C00;
  localparam lfsr_t SEED     = 16'hFFFF;
endpackage

// File: rtl/pscr_keystream.sv
module pscr_keystream
  import pscr_pkg::*;
#(
  parameter int WORD_W = 64
) (
  input  lfsr_t             state_i,
  output logic [WORD_W-1:0] ks_o,
  output lfsr_t             next_o
);
  localparam int LANES = WORD_W / LANE_W;

  lfsr_t walk;

  // unrolled single-bit steps: lane 0 first, bit 0 first inside a lane
  always_comb begin
    walk = state_i;
    ks_o = '0;
    for (int ln = 0; ln < LANES; ln++) begin
      for (int b = 0; b < LANE_W; b++) begin
        ks_o[ln*LANE_W + b] = walk[0];
        if (walk[0]) walk = (walk >> 1) ^ TAP_MASK;
        else         walk = walk >> 1;
      end
    end
    next_o = walk;
  end
endmodule

// File: rtl/pscr_state_reg.sv
module pscr_state_reg
  import pscr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  lfsr_t next_i,
  output lfsr_t state_o
);
  lfsr_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (adv) state_d = next_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  // R5: idle cycles leave the register untouched
  p_state_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(state_q)) else $error("state moved while idle");

  // R2: a full-word step never lands on the same state
  p_state_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> state_q != $past(state_q)) else $error("state did not advance");

  // R2: a Galois register seeded nonzero never reaches zero
  p_state_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0) else $error("state collapsed to zero");
endmodule

// File: rtl/pscr_out_stage.sv
module pscr_out_stage #(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  logic [WORD_W-1:0] ks,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data
);
  logic [WORD_W-1:0] data_q, data_d;
  logic              vld_q, vld_d;

  always_comb begin
    vld_d  = in_valid;
    data_d = data_q;
    if (in_valid) data_d = in_data ^ ks;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q  <= vld_d;
      data_q <= data_d;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = data_q;

  // R6: strobe follows the input one cycle later
  p_valid_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid) else $error("out_valid missing");
  p_idle_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid) else $error("spurious out_valid");

  // R5: output word holds through idle cycles
  p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data)) else $error("out_data changed while idle");
endmodule

// File: rtl/pipe_scrambler.sv
module pipe_scrambler
  import pscr_pkg::*;
#(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data
);
  lfsr_t             state, next_state;
  logic [WORD_W-1:0] ks;

  pscr_keystream #(.WORD_W(WORD_W)) u_ks (
    .state_i (state),
    .ks_o    (ks),
    .next_o  (next_state)
  );

  pscr_state_reg u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (in_valid),
    .next_i  (next_state),
    .state_o (state)
  );

  pscr_out_stage #(.WORD_W(WORD_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .ks        (ks),
    .out_valid (out_valid),
    .out_data  (out_data)
  );
endmodule

// File: tb/sim_pipe_scrambler.sv
`timescale 1ns/1ps
module sim_pipe_scrambler;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        a_valid;
  logic [63:0] a_data;
  logic        a_ovalid, d_ovalid;
  logic [63:0] a_odata, d_odata;
  logic        b_valid, b_ovalid;
  logic [7:0]  b_data, b_odata;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [15:0] m_state;
  logic [63:0] sent [128];
  logic [63:0] scr  [128];

  always #4 clk = ~clk;

  pipe_scrambler u0 (.clk(clk), .rst_n(rst_n), .in_valid(a_valid), .in_data(a_data),
                     .out_valid(a_ovalid), .out_data(a_odata));
  pipe_scrambler u1 (.clk(clk), .rst_n(rst_n), .in_valid(a_ovalid), .in_data(a_odata),
                     .out_valid(d_ovalid), .out_data(d_odata));
  pipe_scrambler #(.WORD_W(8)) u2 (.clk(clk), .rst_n(rst_n), .in_valid(b_valid),
                     .in_data(b_data), .out_valid(b_ovalid), .out_data(b_odata));

  // {valid, data}
  localparam logic [64:0] VEC [12] = '{
    {1'b1, 64'h0000_0000_0000_0000},
    {1'b1, 64'hFFFF_FFFF_FFFF_FFFF},
    {1'b0, 64'h1234_5678_9ABC_DEF0},
    {1'b0, 64'hDEAD_BEEF_0000_0001},
    {1'b1, 64'h0123_4567_89AB_CDEF},
    {1'b1, 64'h0000_0000_0000_0000},
    {1'b0, 64'hFFFF_0000_FFFF_0000},
    {1'b1, 64'h8000_0000_0000_0001},
    {1'b1, 64'hA5A5_A5A5_5A5A_5A5A},
    {1'b0, 64'h0000_0000_0000_0000},
    {1'b1, 64'h0F0F_0F0F_F0F0_F0F0},
    {1'b1, 64'h0000_0000_0000_0000}
  };

  task automatic model_ks(input int nbits, output logic [63:0] ks);
    ks = '0;
    for (int i = 0; i < nbits; i++) begin
      ks[i] = m_state[0];
      if (m_state[0]) m_state = (m_state >> 1) ^ 16'h9C00;
      else            m_state = m_state >> 1;
    end
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] count_word(input int w);
    logic [63:0] r;
    for (int j = 0; j < 8; j++) r[8*j +: 8] = 8'((w*8 + j) & 255);
    return r;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] ks, last;
    int tx, rx, sidx, cyc;

    // ---- reset, with a valid word held on the input (R1, R9)
    rst_n = 1'b0; a_valid = 1'b1; a_data = 64'hFFFF_FFFF_FFFF_FFFF;
    b_valid = 1'b0; b_data = '0;
    repeat (3) tick();
    chk("R1 out_valid in reset", {63'd0, a_ovalid}, 64'd0);
    chk("R9 out_data in reset", a_odata, 64'd0);
    a_valid = 1'b0;
    rst_n = 1'b1;
    tick();
    chk("R1 out_valid after reset", {63'd0, a_ovalid}, 64'd0);
    chk("R1 out_data after reset", a_odata, 64'd0);

    // ---- vector table walk (R2 R3 R4 R5 R6)
    m_state = 16'hFFFF;
    last = '0;
    for (int v = 0; v < 12; v++) begin
      a_valid = VEC[v][64];
      a_data  = VEC[v][63:0];
      tick();
      if (VEC[v][64]) begin
        model_ks(64, ks);
        last = VEC[v][63:0] ^ ks;
        chk("R4 scrambled word", a_odata, last);
        chk("R6 out_valid high", {63'd0, a_ovalid}, 64'd1);
      end else begin
        chk("R5 hold while idle", a_odata, last);
        chk("R6 out_valid low", {63'd0, a_ovalid}, 64'd0);
      end
      if (v == 0) chk("R2 seed keystream bytes", {40'd0, a_odata[23:0]}, 64'hC017FF);
    end
    a_valid = 1'b0;
    tick();

    // ---- mid-stream reset, then counting pattern through both instances (R10 R8 R3)
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    tick();
    tx = 0; rx = 0; sidx = 0; cyc = 0;
    while (rx < 128 && cyc < 2000) begin
      if (d_ovalid) begin
        chk("R8 round trip", d_odata, sent[rx]);
        rx++;
      end
      if (a_ovalid) begin
        if (sidx == 0) begin
          chk("R10 reseeded first word", {40'd0, a_odata[23:0]}, 64'hC216FF);
          chk("R3 lane order first word", {40'd0, a_odata[23:0] ^ 24'h020100}, 64'hC017FF);
        end
        scr[sidx] = a_odata;
        sidx++;
      end
      if (tx < 128 && (cyc % 5) != 4) begin
        sent[tx] = count_word(tx);
        a_valid = 1'b1;
        a_data = sent[tx];
        tx++;
      end else begin
        a_valid = 1'b0;
      end
      tick();
      cyc++;
    end
    a_valid = 1'b0;
    chk("R8 all words returned", 64'(rx), 64'd128);

    // ---- 8-bit instance on the same byte stream (R7)
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    tick();
    tx = 0; rx = 0; cyc = 0;
    while (rx < 1024 && cyc < 4000) begin
      if (b_ovalid) begin
        chk("R7 byte match across widths", {56'd0, b_odata}, {56'd0, scr[rx/8][8*(rx%8) +: 8]});
        rx++;
      end
      if (tx < 1024 && (cyc % 7) != 6) begin
        b_valid = 1'b1;
        b_data = 8'(tx & 255);
        tx++;
      end else begin
        b_valid = 1'b0;
      end
      tick();
      cyc++;
    end
    b_valid = 1'b0;
    chk("R7 all bytes produced", 64'(rx), 64'd1024);

    // ---- reset asserted while valid is high (R9)
    a_valid = 1'b1; a_data = 64'h5555_5555_5555_5555;
    tick();
    a_data = '0;
    rst_n = 1'b0;
    tick();
    tick();
    chk("R9 no output under reset", {63'd0, a_ovalid}, 64'd0);
    rst_n = 1'b1;
    tick();
    m_state = 16'hFFFF;
    model_ks(64, ks);
    chk("R9 seed keystream after release", a_odata, ks);
    chk("R9 out_valid after release", {63'd0, a_ovalid}, 64'd1);
    a_valid = 1'b0;
    tick();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule